// File: doc/BRIEF.md
# Paging MMU Command and Status Register Block

This block is the software-facing control plane of a small paging memory management unit. A host reaches it through a plain 32-bit register bus. A read returns its data one cycle after the request. Through that bus the host programs the page-directory base, issues numbered commands and reads back the unit's state.

The translation engine sits beside this block and reports page faults and bus read errors to it. In return, the block drives the engine's paging-enable, stall and fault-hold levels, plus single-cycle invalidate requests for the translation cache. Raw interrupt causes are kept per bit, cleared by writing ones and filtered by a mask. A single interrupt line is the OR of the unmasked causes.

All bus pins and engine pins are plain level or pulse signals. No data stream crosses this block, so it has no valid/ready handshake and never applies back-pressure. A read request always completes on the next cycle, with `bus_rvalid` high for that one cycle.

Top module: `mmu_ctl_top`

## Requirements
- R1: A write to the directory-base register (offset 0x00) keeps only data bits 31:12. Reads and the `dir_base` output show bits 11:0 as zero, so 0xCAFEBABE reads back as 0xCAFEB000.
- R2: Writing the value 0 to the command register (offset 0x08) turns paging on, and writing 1 turns it off. Paging state appears at status bit 0 and on `paging_on`. Any command value above 6 changes nothing.
- R3: After command 2 is accepted, stall-active (status bit 2, `stall_on`) rises only in the cycle after `eng_idle` is seen high. Status bit 31 always reads as the inverse of stall-active.
- R4: Command 2 is ignored while paging is off or while a page fault is active. Stall-active stays 0 even when `eng_idle` is high.
- R5: Command 3 withdraws any stall request and clears stall-active on the next clock edge.
- R6: A fault report (`flt_valid`) arriving while paging is on and no fault is held sets fault-active (status bit 1, `fault_on`). It latches `flt_addr` into the fault-address register (offset 0x0C) and `flt_write` into status bit 5, and it sets raw interrupt bit 0. A report that arrives while a fault is held, or while paging is off, is ignored.
- R7: Command 5 clears fault-active. The latched fault address is kept.
- R8: A `rd_bus_err` pulse sets raw interrupt bit 1. Both raw bits (offset 0x14) may be pending together.
- R9: Writing the clear register (offset 0x18) clears each raw bit written as 1 and leaves the others unchanged. A cause that arrives in the same cycle stays set.
- R10: The masked status (offset 0x20) equals raw AND mask, where the mask register is at offset 0x1C. `irq` is high exactly when the masked status is nonzero.
- R11: Command 4 produces exactly one cycle of `inv_all`, in the cycle after the write.
- R12: A write to the single-line invalidate register (offset 0x10) produces exactly one cycle of `inv_one` in the cycle after the write, with `inv_addr` equal to the written data.
- R13: Command 6 returns the directory base, paging, stall, fault state, fault address, fault direction, raw interrupts, mask and the gating register to zero.
- R14: The clock-gating register (offset 0x24) holds bit 0, reads it back and drives `gate_en`. Writes to status or masked status are ignored. Write-only and unmapped offsets read as zero. Status bits 3 and 4 mirror `eng_idle` and `rbuf_empty`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after the request |
| bus_rvalid | output | 1 | Read data valid |
| eng_idle | input | 1 | Translation engine has no access in flight |
| rbuf_empty | input | 1 | Engine replay buffer is empty |
| flt_valid | input | 1 | Engine reports a page fault this cycle |
| flt_addr | input | 32 | Faulting virtual address |
| flt_write | input | 1 | Faulting access was a write |
| rd_bus_err | input | 1 | Engine saw a bus read error this cycle |
| paging_on | output | 1 | Translation enabled |
| stall_on | output | 1 | Engine is held in stall |
| fault_on | output | 1 | A page fault is held |
| dir_base | output | 32 | Page-directory base, low 12 bits zero |
| gate_en | output | 1 | Clock auto-gating enable |
| inv_all | output | 1 | One-cycle request to invalidate the whole translation cache |
| inv_one | output | 1 | One-cycle request to invalidate one entry |
| inv_addr | output | 32 | Address for `inv_one` |
| irq | output | 1 | Interrupt, OR of masked causes |

## Verification
The bench builds the block at its defaults: a 6-bit byte offset, two interrupt causes and a 12-bit page shift. At these settings the whole raw-by-mask space of 16 combinations is swept and checked against the arithmetic AND. Every value of the low command range, including the unused code 7, is applied. A spread of directory-base patterns is compared with the value computed by masking off the low 12 bits. The small cause count also makes it cheap to build the stall and fault orderings (stall refused under fault, a fault ignored while one is held) as explicit sequences.

// File: rtl/mmu_ctl_pkg.sv
package mmu_ctl_pkg;

  localparam logic [7:0] OFS_BASE   = 8'h00;
  localparam logic [7:0] OFS_STATUS = 8'h04;
  localparam logic [7:0] OFS_CMD    = 8'h08;
  localparam logic [7:0] OFS_FADDR  = 8'h0C;
  localparam logic [7:0] OFS_ZAP1   = 8'h10;
  localparam logic [7:0] OFS_RAW    = 8'h14;
  localparam logic [7:0] OFS_CLR    = 8'h18;
  localparam logic [7:0] OFS_MASK   = 8'h1C;
  localparam logic [7:0] OFS_MSTAT  = 8'h20;
  localparam logic [7:0] OFS_GATE   = 8'h24;

  typedef enum logic [2:0] {
    CMD_PG_ON     = 3'd0,
    CMD_PG_OFF    = 3'd1,
    CMD_STALL_ON  = 3'd2,
    CMD_STALL_OFF = 3'd3,
    CMD_FLUSH_ALL = 3'd4,
    CMD_FAULT_ACK = 3'd5,
    CMD_HARD_RST  = 3'd6
  } mmu_cmd_e;

  typedef struct packed {
    logic base;
    logic status;
    logic cmd;
    logic faddr;
    logic zap1;
    logic raw;
    logic clr;
    logic mask;
    logic mstat;
    logic gate;
  } reg_sel_t;

  // status bit positions
  localparam int ST_PAGING  = 0;
  localparam int ST_FAULT   = 1;
  localparam int ST_STALL   = 2;
  localparam int ST_IDLE    = 3;
  localparam int ST_RBUF    = 4;
  localparam int ST_FWRITE  = 5;
  localparam int ST_NSTALL  = 31;

endpackage

// File: rtl/mmu_ctl_decode.sv
module mmu_ctl_decode
  import mmu_ctl_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_t          sel
);

  function automatic logic is_at(input logic [ADDR_W-1:0] a, input logic [7:0] ofs);
    return a == ADDR_W'(ofs);
  endfunction

  always_comb begin
    sel        = '0;
    sel.base   = is_at(addr, OFS_BASE);
    sel.status = is_at(addr, OFS_STATUS);
    sel.cmd    = is_at(addr, OFS_CMD);
    sel.faddr  = is_at(addr, OFS_FADDR);
    sel.zap1   = is_at(addr, OFS_ZAP1);
    sel.raw    = is_at(addr, OFS_RAW);
    sel.clr    = is_at(addr, OFS_CLR);
    sel.mask   = is_at(addr, OFS_MASK);
    sel.mstat  = is_at(addr, OFS_MSTAT);
    sel.gate   = is_at(addr, OFS_GATE);
  end

endmodule

// File: rtl/mmu_ctl_cmd.sv
module mmu_ctl_cmd
  import mmu_ctl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_wr,
  input  logic [31:0] cmd_code,
  input  logic        eng_idle,
  input  logic        flt_valid,
  input  logic [31:0] flt_addr,
  input  logic        flt_write,
  output logic        paging,
  output logic        stall,
  output logic        fault,
  output logic [31:0] fault_addr,
  output logic        fault_wr,
  output logic        flt_event,
  output logic        flush_pulse,
  output logic        hard_rst
);

  logic stall_req;

  function automatic logic is_cmd(input logic [31:0] v, input mmu_cmd_e c);
    return v == 32'(c);
  endfunction

  logic do_pg_on, do_pg_off, do_st_on, do_st_off, do_flush, do_ack;

  always_comb begin
    do_pg_on  = cmd_wr && is_cmd(cmd_code, CMD_PG_ON);
    do_pg_off = cmd_wr && is_cmd(cmd_code, CMD_PG_OFF);
    do_st_on  = cmd_wr && is_cmd(cmd_code, CMD_STALL_ON) && paging && !fault;
    do_st_off = cmd_wr && is_cmd(cmd_code, CMD_STALL_OFF);
    do_flush  = cmd_wr && is_cmd(cmd_code, CMD_FLUSH_ALL);
    do_ack    = cmd_wr && is_cmd(cmd_code, CMD_FAULT_ACK);
    hard_rst  = cmd_wr && is_cmd(cmd_code, CMD_HARD_RST);
    flt_event = flt_valid && paging && !fault && !hard_rst;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      paging      <= 1'b0;
      stall_req   <= 1'b0;
      stall       <= 1'b0;
      fault       <= 1'b0;
      fault_addr  <= '0;
      fault_wr    <= 1'b0;
      flush_pulse <= 1'b0;
    end else if (hard_rst) begin
      paging      <= 1'b0;
      stall_req   <= 1'b0;
      stall       <= 1'b0;
      fault       <= 1'b0;
      fault_addr  <= '0;
      fault_wr    <= 1'b0;
      flush_pulse <= 1'b0;
    end else begin
      flush_pulse <= do_flush;
      if (do_pg_on)  paging <= 1'b1;
      if (do_pg_off) paging <= 1'b0;
      // stall request and its idle-qualified acknowledge
      if (do_st_off)     stall_req <= 1'b0;
      else if (do_st_on) stall_req <= 1'b1;
      if (do_st_off || !stall_req) stall <= 1'b0;
      else if (eng_idle)           stall <= 1'b1;
      // fault capture and release
      if (flt_event) begin
        fault      <= 1'b1;
        fault_addr <= flt_addr;
        fault_wr   <= flt_write;
      end else if (do_ack) begin
        fault <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/mmu_ctl_irq.sv
module mmu_ctl_irq #(
  parameter int NUM_IRQ = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               soft_clr,
  input  logic [NUM_IRQ-1:0] set_vec,
  input  logic               clr_wr,
  input  logic [NUM_IRQ-1:0] clr_bits,
  input  logic               mask_wr,
  input  logic [NUM_IRQ-1:0] mask_bits,
  output logic [NUM_IRQ-1:0] raw,
  output logic [NUM_IRQ-1:0] mask,
  output logic [NUM_IRQ-1:0] masked,
  output logic               irq
);

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_cause
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      raw[i] <= 1'b0;
      else if (soft_clr)               raw[i] <= 1'b0;
      else if (set_vec[i])             raw[i] <= 1'b1;
      else if (clr_wr && clr_bits[i])  raw[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mask <= '0;
    else if (soft_clr) mask <= '0;
    else if (mask_wr)  mask <= mask_bits;
  end

  assign masked = raw & mask;
  assign irq    = |masked;

endmodule

// File: rtl/mmu_ctl_top.sv
module mmu_ctl_top
  import mmu_ctl_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int NUM_IRQ    = 2,
  parameter int PAGE_SHIFT = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  input  logic              eng_idle,
  input  logic              rbuf_empty,
  input  logic              flt_valid,
  input  logic [31:0]       flt_addr,
  input  logic              flt_write,
  input  logic              rd_bus_err,
  output logic              paging_on,
  output logic              stall_on,
  output logic              fault_on,
  output logic [31:0]       dir_base,
  output logic              gate_en,
  output logic              inv_all,
  output logic              inv_one,
  output logic [31:0]       inv_addr,
  output logic              irq
);

  localparam int BASE_W = 32 - PAGE_SHIFT;

  reg_sel_t sel;
  logic     wr_en, rd_en;
  logic     hard_rst, flt_event, fault_wr;
  logic [31:0] flt_addr_q;
  logic [NUM_IRQ-1:0] irq_raw, irq_mask, irq_masked, set_vec;
  logic [BASE_W-1:0] base_q;
  logic gate_q, inv_one_q;
  logic [31:0] inv_addr_q, rd_mux, status_w;

  assign wr_en = bus_req && bus_we;
  assign rd_en = bus_req && !bus_we;

  mmu_ctl_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .sel  (sel)
  );

  mmu_ctl_cmd u_cmd (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_wr      (wr_en && sel.cmd),
    .cmd_code    (bus_wdata),
    .eng_idle    (eng_idle),
    .flt_valid   (flt_valid),
    .flt_addr    (flt_addr),
    .flt_write   (flt_write),
    .paging      (paging_on),
    .stall       (stall_on),
    .fault       (fault_on),
    .fault_addr  (flt_addr_q),
    .fault_wr    (fault_wr),
    .flt_event   (flt_event),
    .flush_pulse (inv_all),
    .hard_rst    (hard_rst)
  );

  assign set_vec = NUM_IRQ'({rd_bus_err, flt_event});

  mmu_ctl_irq #(.NUM_IRQ(NUM_IRQ)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_clr  (hard_rst),
    .set_vec   (set_vec),
    .clr_wr    (wr_en && sel.clr),
    .clr_bits  (bus_wdata[NUM_IRQ-1:0]),
    .mask_wr   (wr_en && sel.mask),
    .mask_bits (bus_wdata[NUM_IRQ-1:0]),
    .raw       (irq_raw),
    .mask      (irq_mask),
    .masked    (irq_masked),
    .irq       (irq)
  );

  // directory base, gating and single-line invalidate
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q     <= '0;
      gate_q     <= 1'b0;
      inv_one_q  <= 1'b0;
      inv_addr_q <= '0;
    end else begin
      inv_one_q <= wr_en && sel.zap1;
      if (wr_en && sel.zap1) inv_addr_q <= bus_wdata;
      if (hard_rst) begin
        base_q <= '0;
        gate_q <= 1'b0;
      end else begin
        if (wr_en && sel.base) base_q <= bus_wdata[31:PAGE_SHIFT];
        if (wr_en && sel.gate) gate_q <= bus_wdata[0];
      end
    end
  end

  assign dir_base = {base_q, {PAGE_SHIFT{1'b0}}};
  assign gate_en  = gate_q;
  assign inv_one  = inv_one_q;
  assign inv_addr = inv_addr_q;

  always_comb begin
    status_w             = '0;
    status_w[ST_PAGING]  = paging_on;
    status_w[ST_FAULT]   = fault_on;
    status_w[ST_STALL]   = stall_on;
    status_w[ST_IDLE]    = eng_idle;
    status_w[ST_RBUF]    = rbuf_empty;
    status_w[ST_FWRITE]  = fault_wr;
    status_w[ST_NSTALL]  = !stall_on;
  end

  always_comb begin
    rd_mux = '0;
    if (sel.base)   rd_mux = dir_base;
    if (sel.status) rd_mux = status_w;
    if (sel.faddr)  rd_mux = flt_addr_q;
    if (sel.raw)    rd_mux = 32'(irq_raw);
    if (sel.mask)   rd_mux = 32'(irq_mask);
    if (sel.mstat)  rd_mux = 32'(irq_masked);
    if (sel.gate)   rd_mux = {31'b0, gate_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= rd_en;
      if (rd_en) bus_rdata <= rd_mux;
    end
  end

endmodule

// File: rtl/mmu_ctl_chk.sv
module mmu_ctl_chk #(
  parameter int NUM_IRQ = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               eng_idle,
  input logic               stall_on,
  input logic               fault_on,
  input logic [31:0]        fault_addr,
  input logic               inv_all,
  input logic               inv_one,
  input logic [NUM_IRQ-1:0] raw,
  input logic               irq
);

  p_stall_after_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stall_on) |-> $past(eng_idle));

  p_fault_sets_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_on) |-> raw[0]);

  p_fault_addr_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_on && $past(fault_on)) |-> $stable(fault_addr));

  p_irq_needs_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (raw == '0) |-> !irq);

  p_flush_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> !inv_all);

  p_line_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
    inv_one |=> !inv_one);

endmodule

bind mmu_ctl_top mmu_ctl_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .eng_idle   (eng_idle),
  .stall_on   (stall_on),
  .fault_on   (fault_on),
  .fault_addr (flt_addr_q),
  .inv_all    (inv_all),
  .inv_one    (inv_one),
  .raw        (irq_raw),
  .irq        (irq)
);

// File: tb/sim_mmu_ctl_top.sv
module sim_mmu_ctl_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        eng_idle = 1'b0, rbuf_empty = 1'b1;
  logic        flt_valid = 1'b0, flt_write = 1'b0, rd_bus_err = 1'b0;
  logic [31:0] flt_addr = '0;
  logic        paging_on, stall_on, fault_on, gate_en, inv_all, inv_one, irq;
  logic [31:0] dir_base, inv_addr;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  mmu_ctl_top u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_req = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic fault(input logic [31:0] a, input logic w);
    flt_valid = 1'b1; flt_addr = a; flt_write = w;
    @(negedge clk);
    flt_valid = 1'b0;
  endtask

  function automatic logic [31:0] st(input logic pg, input logic fl, input logic sl, input logic fw);
    return {~sl, 25'b0, fw, rbuf_empty, eng_idle, sl, fl, pg};
  endfunction

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    rd(6'h04, v); chk("R14 reset status", v, st(0, 0, 0, 0));
    rd(6'h00, v); chk("R1 reset base", v, 32'h0);
    chk("R10 reset irq", {31'b0, irq}, 32'h0);

    // R1 directory base sweep
    wr(6'h00, 32'hCAFEBABE);
    rd(6'h00, v); chk("R1 base CAFEBABE", v, 32'hCAFEB000);
    for (int i = 0; i < 16; i++) begin
      logic [31:0] p;
      p = (32'h9E37_79B9 * (i + 1)) ^ (32'(i) << 28);
      wr(6'h00, p);
      rd(6'h00, v); chk("R1 base sweep", v, p & 32'hFFFF_F000);
      chk("R1 dir_base port", dir_base, p & 32'hFFFF_F000);
    end

    // R4: stall refused with paging off
    eng_idle = 1'b1;
    wr(6'h08, 32'd2); idle(3);
    rd(6'h04, v); chk("R4 stall paging off", v, st(0, 0, 0, 0));

    // R2 paging on/off and unused code
    wr(6'h08, 32'd0);
    rd(6'h04, v); chk("R2 paging on", v, st(1, 0, 0, 0));
    chk("R2 paging_on port", {31'b0, paging_on}, 32'h1);
    wr(6'h08, 32'd7);
    rd(6'h04, v); chk("R2 code 7 ignored", v, st(1, 0, 0, 0));
    wr(6'h08, 32'd1);
    rd(6'h04, v); chk("R2 paging off", v, st(0, 0, 0, 0));
    wr(6'h08, 32'd0);

    // R3 stall waits for idle
    eng_idle = 1'b0;
    wr(6'h08, 32'd2); idle(4);
    rd(6'h04, v); chk("R3 stall waits idle", v, st(1, 0, 0, 0));
    eng_idle = 1'b1; idle(2);
    rd(6'h04, v); chk("R3 stall active", v, st(1, 0, 1, 0));
    chk("R3 stall_on port", {31'b0, stall_on}, 32'h1);

    // R5 disable stall
    wr(6'h08, 32'd3);
    rd(6'h04, v); chk("R5 stall cleared", v, st(1, 0, 0, 0));

    // R6 fault capture
    fault(32'h1357_9BDF, 1'b1);
    rd(6'h04, v); chk("R6 fault status", v, st(1, 1, 0, 1));
    rd(6'h0C, v); chk("R6 fault addr", v, 32'h1357_9BDF);
    rd(6'h14, v); chk("R6 raw bit0", v, 32'h1);
    fault(32'h2468_ACE0, 1'b0);
    rd(6'h0C, v); chk("R6 second fault ignored", v, 32'h1357_9BDF);
    rd(6'h04, v); chk("R6 direction kept", v, st(1, 1, 0, 1));

    // R4 stall refused under fault
    wr(6'h08, 32'd2); idle(3);
    rd(6'h04, v); chk("R4 stall under fault", v, st(1, 1, 0, 1));

    // R7 fault done
    wr(6'h08, 32'd5);
    rd(6'h04, v); chk("R7 fault cleared", v, st(1, 0, 0, 1));
    rd(6'h0C, v); chk("R7 addr kept", v, 32'h1357_9BDF);

    // R8 bus error, both pending
    rd_bus_err = 1'b1; @(negedge clk); rd_bus_err = 1'b0;
    rd(6'h14, v); chk("R8 both causes", v, 32'h3);

    // R9 write-one-to-clear
    wr(6'h18, 32'h1);
    rd(6'h14, v); chk("R9 clear bit0", v, 32'h2);
    wr(6'h18, 32'h2);
    rd(6'h14, v); chk("R9 clear bit1", v, 32'h0);

    // R10 exhaustive raw x mask sweep
    for (int r = 0; r < 4; r++) begin
      for (int m = 0; m < 4; m++) begin
        wr(6'h18, 32'h3);
        if (r[0]) begin fault(32'h0000_1000 * (r + 1), 1'b0); wr(6'h08, 32'd5); end
        if (r[1]) begin rd_bus_err = 1'b1; @(negedge clk); rd_bus_err = 1'b0; end
        wr(6'h1C, 32'(m));
        rd(6'h14, v); chk("R10 raw", v, 32'(r));
        rd(6'h20, v); chk("R10 masked", v, 32'(r & m));
        chk("R10 irq", {31'b0, irq}, {31'b0, (r & m) != 0});
      end
    end

    // R14 read-only writes ignored, unmapped reads zero, gating
    wr(6'h20, 32'h0); wr(6'h04, 32'hFFFF_FFFF);
    rd(6'h20, v); chk("R14 mstat write ignored", v, 32'h3);
    rd(6'h04, v); chk("R14 status write ignored", v, st(1, 0, 0, 0));
    rd(6'h3C, v); chk("R14 unmapped reads zero", v, 32'h0);
    rd(6'h08, v); chk("R14 command reads zero", v, 32'h0);
    wr(6'h24, 32'h1);
    rd(6'h24, v); chk("R14 gate readback", v, 32'h1);
    chk("R14 gate_en port", {31'b0, gate_en}, 32'h1);

    // R11 flush pulse
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = 6'h08; bus_wdata = 32'd4;
    @(negedge clk); bus_req = 1'b0;
    chk("R11 inv_all high", {31'b0, inv_all}, 32'h1);
    @(negedge clk);
    chk("R11 inv_all single", {31'b0, inv_all}, 32'h0);

    // R12 single-line invalidate
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = 6'h10; bus_wdata = 32'hABCD_E123;
    @(negedge clk); bus_req = 1'b0;
    chk("R12 inv_one high", {31'b0, inv_one}, 32'h1);
    chk("R12 inv_addr", inv_addr, 32'hABCD_E123);
    @(negedge clk);
    chk("R12 inv_one single", {31'b0, inv_one}, 32'h0);

    // R13 hard reset
    wr(6'h00, 32'h8765_4321);
    fault(32'h5555_0000, 1'b1);
    wr(6'h08, 32'd6);
    rd(6'h00, v); chk("R13 base zero", v, 32'h0);
    rd(6'h04, v); chk("R13 status", v, st(0, 0, 0, 0));
    rd(6'h0C, v); chk("R13 fault addr", v, 32'h0);
    rd(6'h14, v); chk("R13 raw", v, 32'h0);
    rd(6'h1C, v); chk("R13 mask", v, 32'h0);
    rd(6'h24, v); chk("R13 gate", v, 32'h0);
    chk("R13 irq", {31'b0, irq}, 32'h0);

    // R6 fault ignored while paging off
    fault(32'h7777_7000, 1'b0);
    rd(6'h04, v); chk("R6 fault paging off", v, st(0, 0, 0, 0));
    rd(6'h14, v); chk("R6 no cause paging off", v, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule